// File: doc/BRIEF.md
# SDRAM Command Decoder and Bank Tracker

This block watches the control pins of a four-bank synchronous DRAM on every rising clock edge. It names the command that the strobes encode and keeps a live picture of each bank: idle, open, bursting out, bursting in, or closing. It also follows the device-wide clock-enable modes, which are power-down, self-refresh and clock suspend. It raises a one-cycle flag whenever the command it sees is not allowed in the current bank or device state. Typical uses are a protocol monitor beside a memory controller, or the front end of a behavioural memory model.

All outputs are registered. A command sampled at edge k shows on the outputs just after edge k. Closing and refresh are timed with per-bank down-counters, loaded from the parameters `T_RP` and `T_RC`. Burst duration is set by `BURST_LEN`. No data moves through the block, so it has no valid/ready stream. Every pin is plain control or status and is sampled every cycle without back-pressure.

Top module: `sdram_cmd_tracker`

## Requirements
- R1: With `cs_n` high the command is deselect, whatever the strobes show. Otherwise {ras_n,cas_n,we_n} decodes as follows: 011 ACT, 101 READ, 100 WRITE, 010 PRE, 001 REFA, 000 MRS, 110 burst stop, 111 NOP. `cmd_o` codes are: 0 deselect, 1 NOP, 2 ACT, 3 READ, 4 READ+autoclose, 5 WRITE, 6 WRITE+autoclose, 7 PRE, 8 PRE-all, 9 REFA, 10 MRS, 11 burst stop.
- R2: With `a10` high, READ and WRITE take their autoclose forms (codes 4 and 6). When such a burst ends, the bank closes for `T_RP` cycles and then goes idle. With `a10` high, PRE becomes PRE-all (code 8) and closes every open bank at once.
- R3: ACT to an idle bank makes it active (state 1). ACT to any bank that is not idle raises `illegal_o` and changes nothing.
- R4: READ, WRITE or burst stop aimed at a bank that is idle (0) or closing (4) raises `illegal_o` and leaves every bank unchanged.
- R5: READ or WRITE to an open bank puts it in state 2 (reading) or 3 (writing) for `BURST_LEN` unfrozen cycles, after which it returns to active. A new command aimed at the same bank overrides this.
- R6: PRE to an open bank puts it in state 4 for `T_RP` cycles, after which it is idle. PRE to an idle bank is legal and has no effect.
- R7: REFA and MRS are illegal unless every bank is idle. A legal REFA puts all banks in state 4 for `T_RC` cycles.
- R8: Burst stop to a reading or writing bank returns it to active at once and cancels any pending autoclose.
- R9: `dev_state_o` codes are 0 normal, 1 power-down, 2 self-refresh, 3 clock suspend. In normal state, with `cke` low and all banks idle, the outcome depends on the command. REFA enters self-refresh. NOP or deselect enters power-down. Any other command is illegal and leaves the state unchanged.
- R10: Power-down holds while `cke` stays low, and commands have no effect. `cke` high returns the device to normal.
- R11: Self-refresh holds while `cke` is low. `cke` high with NOP or deselect returns the device to normal, with all banks closing for `T_RC` cycles. `cke` high with any other command is illegal, and the device stays in self-refresh.
- R12: With `cke` low while some bank is not idle, the command at that edge still acts, and the device enters clock suspend. While suspended, commands are ignored and bank state and counters freeze. `cke` high returns the device to normal after that frozen edge.
- R13: Asynchronous reset drives `cmd_o` to 0, `illegal_o` to 0, `dev_state_o` to 0 and every bank to idle. `bank_state_o` holds bank b in bits [3b+2:3b].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all pins are sampled on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write strobe, active low |
| cke | input | 1 | Clock enable for the current cycle |
| ba | input | 2 | Bank address |
| a10 | input | 1 | Autoclose / close-all qualifier |
| cmd_o | output | 4 | Registered command code |
| bank_state_o | output | 12 | Three-bit state per bank |
| illegal_o | output | 1 | One-cycle illegal-command flag |
| dev_state_o | output | 2 | Device clock-enable mode |

## Verification
One cycle-by-cycle vector sequence drives the tracker through several patterns. It sends column commands and burst stop to idle and closing banks, which tells per-bank legality apart from decoding. It sends ACT/READ/WRITE/PRE interleaved across three banks, which shows that only the addressed bank moves and that PRE-all reaches every open bank. It times back-to-back burst and close intervals, which pins the counter load values to exact cycle counts. It toggles `cke` in each device state, which separates power-down, self-refresh and suspend entry and exit. One suspend case freezes a running burst, so a design that keeps counting while suspended ends the burst a cycle early. A reset in the middle of activity closes the run.

// File: rtl/sdct_pkg.sv
package sdct_pkg;

  typedef enum logic [3:0] {
    C_DESEL  = 4'd0,
    C_NOP    = 4'd1,
    C_ACT    = 4'd2,
    C_READ   = 4'd3,
    C_READA  = 4'd4,
    C_WRITE  = 4'd5,
    C_WRITEA = 4'd6,
    C_PRE    = 4'd7,
    C_PREA   = 4'd8,
    C_REFA   = 4'd9,
    C_MRS    = 4'd10,
    C_TBST   = 4'd11
  } cmd_e;

  typedef enum logic [2:0] {
    B_IDLE    = 3'd0,
    B_ACTIVE  = 3'd1,
    B_READING = 3'd2,
    B_WRITING = 3'd3,
    B_PRECHG  = 3'd4
  } bank_e;

  typedef enum logic [1:0] {
    D_NORMAL  = 2'd0,
    D_PWRDN   = 2'd1,
    D_SELFREF = 2'd2,
    D_SUSPEND = 2'd3
  } dev_e;

endpackage

// File: rtl/sdct_decode.sv
module sdct_decode
  import sdct_pkg::*;
(
  input  logic cs_n,
  input  logic ras_n,
  input  logic cas_n,
  input  logic we_n,
  input  logic a10,
  output cmd_e cmd
);

  always_comb begin
    if (cs_n) begin
      cmd = C_DESEL;
    end else begin
      case ({ras_n, cas_n, we_n})
        3'b011:  cmd = C_ACT;
        3'b101:  cmd = a10 ? C_READA : C_READ;
        3'b100:  cmd = a10 ? C_WRITEA : C_WRITE;
        3'b010:  cmd = a10 ? C_PREA : C_PRE;
        3'b001:  cmd = C_REFA;
        3'b000:  cmd = C_MRS;
        3'b110:  cmd = C_TBST;
        default: cmd = C_NOP;
      endcase
    end
  end

endmodule

// File: rtl/sdct_bank.sv
module sdct_bank
  import sdct_pkg::*;
#(
  parameter int T_RP      = 3,
  parameter int T_RC      = 7,
  parameter int BURST_LEN = 4,
  parameter int CNT_W     = 3
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  apply,
  input  logic  tick,
  input  logic  hit,
  input  cmd_e  cmd,
  input  logic  refresh_load,
  output bank_e state_o,
  output logic  bad_o,
  output logic  idle_o
);

  localparam logic [CNT_W-1:0] RP_LD = CNT_W'(T_RP - 1);
  localparam logic [CNT_W-1:0] RC_LD = CNT_W'(T_RC - 1);
  localparam logic [CNT_W-1:0] BL_LD = CNT_W'(BURST_LEN - 1);

  bank_e            st, st_n;
  logic [CNT_W-1:0] cnt, cnt_n;
  logic             ap, ap_n;
  logic             is_rd, is_wr, is_open, is_burst, is_closed;

  assign is_rd     = (cmd == C_READ) || (cmd == C_READA);
  assign is_wr     = (cmd == C_WRITE) || (cmd == C_WRITEA);
  assign is_burst  = (st == B_READING) || (st == B_WRITING);
  assign is_open   = is_burst || (st == B_ACTIVE);
  assign is_closed = (st == B_IDLE) || (st == B_PRECHG);

  assign bad_o = hit && (((cmd == C_ACT) && (st != B_IDLE)) ||
                         ((is_rd || is_wr || (cmd == C_TBST)) && is_closed));
  assign idle_o  = (st == B_IDLE);
  assign state_o = st;

  always_comb begin
    st_n  = st;
    cnt_n = cnt;
    ap_n  = ap;
    if (tick && (is_burst || st == B_PRECHG)) begin
      if (cnt == '0) begin
        if (st == B_PRECHG) begin
          st_n = B_IDLE;
        end else if (ap) begin
          st_n  = B_PRECHG;
          cnt_n = RP_LD;
          ap_n  = 1'b0;
        end else begin
          st_n = B_ACTIVE;
        end
      end else begin
        cnt_n = cnt - 1'b1;
      end
    end
    if (refresh_load) begin
      st_n  = B_PRECHG;
      cnt_n = RC_LD;
      ap_n  = 1'b0;
    end else if (apply && !bad_o) begin
      case (cmd)
        C_ACT: if (hit) st_n = B_ACTIVE;
        C_READ, C_READA: if (hit) begin
          st_n  = B_READING;
          cnt_n = BL_LD;
          ap_n  = (cmd == C_READA);
        end
        C_WRITE, C_WRITEA: if (hit) begin
          st_n  = B_WRITING;
          cnt_n = BL_LD;
          ap_n  = (cmd == C_WRITEA);
        end
        C_PRE, C_PREA: if ((hit || cmd == C_PREA) && is_open) begin
          st_n  = B_PRECHG;
          cnt_n = RP_LD;
          ap_n  = 1'b0;
        end
        C_TBST: if (hit && is_burst) begin
          st_n = B_ACTIVE;
          ap_n = 1'b0;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st  <= B_IDLE;
      cnt <= '0;
      ap  <= 1'b0;
    end else begin
      st  <= st_n;
      cnt <= cnt_n;
      ap  <= ap_n;
    end
  end

  // R3: a legal activate opens the bank
  p_act_opens_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (apply && hit && cmd == C_ACT && st == B_IDLE && !refresh_load) |=> (st == B_ACTIVE));

  // R4: column command to a closed bank leaves it closed or closing
  p_col_closed_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (apply && hit && (is_rd || is_wr) && st == B_IDLE && !refresh_load) |=> (st == B_IDLE));

  // R6: last closing cycle ends in idle
  p_close_ends_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && st == B_PRECHG && cnt == '0 && !refresh_load) |=> (st == B_IDLE));

  // R8: burst stop on a bursting bank returns it to active
  p_tbst_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (apply && hit && cmd == C_TBST && is_burst && !refresh_load) |=> (st == B_ACTIVE));

endmodule

// File: rtl/sdct_dev.sv
module sdct_dev
  import sdct_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic cke,
  input  cmd_e cmd,
  input  logic all_idle,
  output dev_e dev_o,
  output logic apply_o,
  output logic tick_o,
  output logic sr_exit_o,
  output logic cke_bad_o
);

  dev_e dev, dev_n;
  logic quiet;

  assign quiet = (cmd == C_NOP) || (cmd == C_DESEL);

  always_comb begin
    dev_n     = dev;
    apply_o   = 1'b0;
    tick_o    = 1'b0;
    sr_exit_o = 1'b0;
    cke_bad_o = 1'b0;
    case (dev)
      D_NORMAL: begin
        tick_o = 1'b1;
        if (!cke && all_idle) begin
          if (cmd == C_REFA)  dev_n = D_SELFREF;
          else if (quiet)     dev_n = D_PWRDN;
          else                cke_bad_o = 1'b1;
        end else begin
          apply_o = 1'b1;
          if (!cke) dev_n = D_SUSPEND;
        end
      end
      D_SELFREF: begin
        if (cke) begin
          if (quiet) begin
            dev_n     = D_NORMAL;
            sr_exit_o = 1'b1;
          end else begin
            cke_bad_o = 1'b1;
          end
        end
      end
      D_PWRDN, D_SUSPEND: begin
        if (cke) dev_n = D_NORMAL;
      end
      default: dev_n = D_NORMAL;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) dev <= D_NORMAL;
    else        dev <= dev_n;
  end

  assign dev_o = dev;

  // R10: power-down is only ever held with all banks idle
  p_pd_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (dev == D_PWRDN) |-> all_idle);

  // R11: self-refresh holds while cke stays low
  p_sr_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (dev == D_SELFREF && !cke) |=> (dev == D_SELFREF));

  // R12: suspend ends on the edge that sees cke high
  p_susp_exit_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (dev == D_SUSPEND && cke) |=> (dev == D_NORMAL));

endmodule

// File: rtl/sdram_cmd_tracker.sv
module sdram_cmd_tracker
  import sdct_pkg::*;
#(
  parameter int NUM_BANKS = 4,
  parameter int T_RP      = 3,
  parameter int T_RC      = 7,
  parameter int BURST_LEN = 4,
  localparam int BA_W     = $clog2(NUM_BANKS),
  localparam int BS_W     = 3 * NUM_BANKS
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cs_n,
  input  logic            ras_n,
  input  logic            cas_n,
  input  logic            we_n,
  input  logic            cke,
  input  logic [BA_W-1:0] ba,
  input  logic            a10,
  output logic [3:0]      cmd_o,
  output logic [BS_W-1:0] bank_state_o,
  output logic            illegal_o,
  output logic [1:0]      dev_state_o
);

  localparam int MAX_A = (T_RP > T_RC) ? T_RP : T_RC;
  localparam int MAX_T = (MAX_A > BURST_LEN) ? MAX_A : BURST_LEN;
  localparam int CNT_W = $clog2(MAX_T + 1);

  cmd_e                 cmd_d, cmd_q;
  dev_e                 dev;
  logic                 apply, tick, sr_exit, cke_bad;
  logic                 all_idle, refresh_load, illegal_d, illegal_q;
  logic [NUM_BANKS-1:0] bank_bad, bank_idle;
  bank_e                bst [NUM_BANKS];

  sdct_decode u_dec (
    .cs_n (cs_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
    .a10  (a10),  .cmd  (cmd_d)
  );

  sdct_dev u_dev (
    .clk      (clk),     .rst_n    (rst_n),  .cke     (cke),
    .cmd      (cmd_d),   .all_idle (all_idle),
    .dev_o    (dev),     .apply_o  (apply),  .tick_o  (tick),
    .sr_exit_o(sr_exit), .cke_bad_o(cke_bad)
  );

  assign all_idle     = &bank_idle;
  assign refresh_load = (apply && cmd_d == C_REFA && all_idle) || sr_exit;

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    sdct_bank #(
      .T_RP(T_RP), .T_RC(T_RC), .BURST_LEN(BURST_LEN), .CNT_W(CNT_W)
    ) u_bank (
      .clk         (clk),
      .rst_n       (rst_n),
      .apply       (apply),
      .tick        (tick),
      .hit         (ba == BA_W'(b)),
      .cmd         (cmd_d),
      .refresh_load(refresh_load),
      .state_o     (bst[b]),
      .bad_o       (bank_bad[b]),
      .idle_o      (bank_idle[b])
    );
    assign bank_state_o[3*b +: 3] = bst[b];
  end

  assign illegal_d = cke_bad ||
                     (apply && ((|bank_bad) ||
                      ((cmd_d == C_REFA || cmd_d == C_MRS) && !all_idle)));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_q     <= C_DESEL;
      illegal_q <= 1'b0;
    end else begin
      cmd_q     <= cmd_d;
      illegal_q <= illegal_d;
    end
  end

  assign cmd_o       = cmd_q;
  assign illegal_o   = illegal_q;
  assign dev_state_o = dev;

  // R1: deselect whenever chip select is high
  p_cs_desel_r1: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |=> (cmd_o == 4'd0));

  // R7: refresh with an open bank is flagged
  p_refa_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (dev == D_NORMAL && cke && !cs_n && {ras_n, cas_n, we_n} == 3'b001 && !all_idle)
      |=> illegal_o);

  // R11: self-refresh exit starts every bank closing
  p_sr_exit_r11: assert property (@(posedge clk) disable iff (!rst_n)
    sr_exit |=> (bank_state_o[2:0] == 3'd4));

  // R12: nothing moves while the clock is suspended
  p_susp_freeze_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (dev == D_SUSPEND) |=> $stable(bank_state_o));

endmodule

// File: tb/sdram_cmd_tracker_tb_top.sv
`timescale 1ns/1ps
module sdram_cmd_tracker_tb_top;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cs_n = 1'b1, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1;
  logic       cke = 1'b1, a10 = 1'b0;
  logic [1:0] ba = 2'd0;
  logic [3:0] cmd_o;
  logic [11:0] bank_state_o;
  logic       illegal_o;
  logic [1:0] dev_state_o;
  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  sdram_cmd_tracker dut_i (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n),
    .we_n(we_n), .cke(cke), .ba(ba), .a10(a10), .cmd_o(cmd_o),
    .bank_state_o(bank_state_o), .illegal_o(illegal_o), .dev_state_o(dev_state_o)
  );

  localparam logic [2:0] S_ACT = 3'b011, S_RD = 3'b101, S_WR = 3'b100, S_PRE = 3'b010,
                         S_REF = 3'b001, S_MRS = 3'b000, S_TB = 3'b110, S_NOP = 3'b111;
  localparam logic [3:0] K_DES = 4'd0, K_NOP = 4'd1, K_ACT = 4'd2, K_RD = 4'd3,
                         K_RDA = 4'd4, K_WR = 4'd5, K_WRA = 4'd6, K_PRE = 4'd7,
                         K_PREA = 4'd8, K_REF = 4'd9, K_MRS = 4'd10, K_TB = 4'd11;

  // bank nibbles: bs[15:12]=bank3 ... bs[3:0]=bank0
  function automatic logic [26:0] v(input logic cs, input logic [2:0] rcw, input logic ck,
                                    input logic [1:0] b, input logic a, input logic [3:0] c,
                                    input logic il, input logic [1:0] d, input logic [15:0] bs);
    return {cs, rcw, ck, b, a, c, il, d, bs[14:12], bs[10:8], bs[6:4], bs[2:0]};
  endfunction

  localparam int NV = 64;
  localparam logic [26:0] VEC [NV] = '{
    v(0,S_NOP,1,0,0,K_NOP,0,0,16'h0000),   // R1
    v(1,S_MRS,1,0,0,K_DES,0,0,16'h0000),   // R1 select high masks strobes
    v(0,S_MRS,1,0,0,K_MRS,0,0,16'h0000),   // R7 MRS legal when idle
    v(0,S_RD ,1,0,0,K_RD ,1,0,16'h0000),   // R4
    v(0,S_TB ,1,0,0,K_TB ,1,0,16'h0000),   // R4
    v(0,S_PRE,1,1,0,K_PRE,0,0,16'h0000),   // R6 PRE to idle is a no-op
    v(0,S_ACT,1,0,0,K_ACT,0,0,16'h0001),   // R3
    v(0,S_ACT,1,0,0,K_ACT,1,0,16'h0001),   // R3 second ACT illegal
    v(0,S_MRS,1,0,0,K_MRS,1,0,16'h0001),   // R7
    v(0,S_REF,1,0,0,K_REF,1,0,16'h0001),   // R7
    v(0,S_RD ,1,0,0,K_RD ,0,0,16'h0002),   // R5
    v(0,S_NOP,1,0,0,K_NOP,0,0,16'h0002),
    v(0,S_NOP,1,0,0,K_NOP,0,0,16'h0002),
    v(0,S_NOP,1,0,0,K_NOP,0,0,16'h0002),
    v(0,S_NOP,1,0,0,K_NOP,0,0,16'h0001),   // R5 burst over
    v(0,S_WR ,1,0,1,K_WRA,0,0,16'h0003),   // R2
    v(0,S_NOP,1,0,0,K_NOP,0,0,16'h0003),
    v(0,S_NOP,1,0,0,K_NOP,0,0,16'h0003),
    v(0,S_NOP,1,0,0,K_NOP,0,0,16'h0003),
    v(0,S_NOP,1,0,0,K_NOP,0,0,16'h0004),   // R2 autoclose
    v(0,S_NOP,1,0,0,K_NOP,0,0,16'h0004),
    v(0,S_NOP,1,0,0,K_NOP,0,0,16'h0004),
    v(0,S_NOP,1,0,0,K_NOP,0,0,16'h0000),   // R6 tRP elapsed
    v(0,S_ACT,1,2,0,K_ACT,0,0,16'h0100),
    v(0,S_ACT,1,1,0,K_ACT,0,0,16'h0110),
    v(0,S_RD ,1,2,0,K_RD ,0,0,16'h0210),
    v(0,S_TB ,1,2,0,K_TB ,0,0,16'h0110),   // R8
    v(0,S_PRE,1,1,1,K_PREA,0,0,16'h0440),  // R2 R6 close all
    v(0,S_RD ,1,1,0,K_RD ,1,0,16'h0440),   // R4 closing bank
    v(0,S_NOP,1,0,0,K_NOP,0,0,16'h0440),
    v(0,S_NOP,1,0,0,K_NOP,0,0,16'h0000),
    v(0,S_REF,1,0,0,K_REF,0,0,16'h4444),   // R7
    v(0,S_NOP,1,0,0,K_NOP,0,0,16'h4444),
    v(0,S_NOP,1,0,0,K_NOP,0,0,16'h4444),
    v(0,S_NOP,1,0,0,K_NOP,0,0,16'h4444),
    v(0,S_NOP,1,0,0,K_NOP,0,0,16'h4444),
    v(0,S_NOP,1,0,0,K_NOP,0,0,16'h4444),
    v(0,S_NOP,1,0,0,K_NOP,0,0,16'h4444),
    v(0,S_NOP,1,0,0,K_NOP,0,0,16'h0000),   // R7 tRC elapsed
    v(0,S_NOP,0,0,0,K_NOP,0,1,16'h0000),   // R9 power-down entry
    v(0,S_ACT,0,0,0,K_ACT,0,1,16'h0000),   // R10 ignored
    v(0,S_NOP,1,0,0,K_NOP,0,0,16'h0000),   // R10 exit
    v(0,S_ACT,1,3,0,K_ACT,0,0,16'h1000),
    v(0,S_RD ,0,3,0,K_RD ,0,3,16'h2000),   // R12 acts, then suspend
    v(0,S_ACT,1,0,0,K_ACT,0,0,16'h2000),   // R12 frozen edge ignores ACT
    v(0,S_NOP,1,0,0,K_NOP,0,0,16'h2000),
    v(0,S_NOP,1,0,0,K_NOP,0,0,16'h2000),
    v(0,S_NOP,1,0,0,K_NOP,0,0,16'h2000),
    v(0,S_NOP,1,0,0,K_NOP,0,0,16'h1000),   // R12 frozen cycle not counted
    v(0,S_PRE,1,3,0,K_PRE,0,0,16'h4000),   // R6
    v(0,S_NOP,1,0,0,K_NOP,0,0,16'h4000),
    v(0,S_NOP,1,0,0,K_NOP,0,0,16'h4000),
    v(0,S_NOP,1,0,0,K_NOP,0,0,16'h0000),
    v(0,S_ACT,0,0,0,K_ACT,1,0,16'h0000),   // R9 bad command on cke fall
    v(0,S_REF,0,0,0,K_REF,0,2,16'h0000),   // R9 self-refresh entry
    v(0,S_ACT,1,0,0,K_ACT,1,2,16'h0000),   // R11 bad exit command
    v(1,S_NOP,1,0,0,K_DES,0,0,16'h4444),   // R11 exit
    v(0,S_NOP,1,0,0,K_NOP,0,0,16'h4444),
    v(0,S_NOP,1,0,0,K_NOP,0,0,16'h4444),
    v(0,S_NOP,1,0,0,K_NOP,0,0,16'h4444),
    v(0,S_NOP,1,0,0,K_NOP,0,0,16'h4444),
    v(0,S_NOP,1,0,0,K_NOP,0,0,16'h4444),
    v(0,S_NOP,1,0,0,K_NOP,0,0,16'h4444),
    v(0,S_NOP,1,0,0,K_NOP,0,0,16'h0000)    // R11 tRC after exit
  };

  localparam int VREQ [NV] = '{
    1,1,7,4,4,6,3,3,7,7, 5,5,5,5,5,2,2,2,2,2, 2,2,6,3,3,5,8,6,4,6,
    6,7,7,7,7,7,7,7,7,9, 10,10,3,12,12,12,12,12,12,6, 6,6,6,9,9,11,11,11,11,11,
    11,11,11,11
  };

  task automatic chk(input logic [18:0] exp, input int rq);
    logic [18:0] got;
    got = {cmd_o, illegal_o, dev_state_o, bank_state_o};
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL R%0d: {cmd,ill,dev,banks} actual=%h expected=%h", rq, got, exp);
    end
  endtask

  task automatic step(input logic [26:0] x, input int rq);
    @(negedge clk);
    cs_n = x[26];
    {ras_n, cas_n, we_n} = x[25:23];
    cke = x[22];
    ba  = x[21:20];
    a10 = x[19];
    @(posedge clk);
    #1;
    chk(x[18:0], rq);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk(19'd0, 13);                        // R13 reset state
    @(negedge clk) rst_n = 1'b1;
    for (int i = 0; i < NV; i++) step(VEC[i], VREQ[i]);
    // R5 plain write burst on bank 1
    step(v(0,S_ACT,1,1,0,K_ACT,0,0,16'h0010), 3);
    step(v(0,S_WR ,1,1,0,K_WR ,0,0,16'h0030), 5);
    for (int i = 0; i < 3; i++) step(v(0,S_NOP,1,0,0,K_NOP,0,0,16'h0030), 5);
    step(v(0,S_NOP,1,0,0,K_NOP,0,0,16'h0010), 5);
    // R2 read with autoclose
    step(v(0,S_RD ,1,1,1,K_RDA,0,0,16'h0020), 2);
    for (int i = 0; i < 3; i++) step(v(0,S_NOP,1,0,0,K_NOP,0,0,16'h0020), 2);
    for (int i = 0; i < 3; i++) step(v(0,S_NOP,1,0,0,K_NOP,0,0,16'h0040), 2);
    step(v(0,S_NOP,1,0,0,K_NOP,0,0,16'h0000), 2);
    // R13 reset during activity
    step(v(0,S_ACT,1,2,0,K_ACT,0,0,16'h0100), 3);
    step(v(0,S_RD ,0,2,0,K_RD ,0,3,16'h0200), 12);
    @(negedge clk) rst_n = 1'b0;
    #1;
    chk(19'd0, 13);
    @(negedge clk) rst_n = 1'b1;
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL R13: watchdog expired actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule